// File: doc/BRIEF.md
# Host Serial Port Selector with Lock

This block decides which of two host serial interfaces, I2C or SPI, owns the chip's register access once the chip has entered normal mode. It then makes that choice permanent. It watches the shared slave-select pin for high-to-low transitions and sees every configuration-register write as a strobe plus the written word. It drives two flags: one says SPI is the active port, the other says the choice is frozen.

After each entry into normal mode, I2C is the port in use. A fixed number of falling edges on the select pin (three by default) moves the chip to SPI. Each of the two ports has its own lock rule:
- I2C locks only when a configuration write sets the lock bit.
- SPI locks on any configuration write.

Once the choice is locked, only the hard reset clears it. The reset input covers both a reset pin and a loss of power. A locked choice holds through every power-mode change, while an unlocked choice falls back to I2C when normal mode is entered again. The select pin arrives without a clock relationship, so it passes through a synchroniser before its edges are counted.

Top module: `serial_port_selector`

## Requirements
- R1: While `rstN` is low and after it is released, `spiSelected` and `portLocked` are 0 and the edge count is zero.
- R2: With `normalMode` high and the choice unlocked with I2C active, the third falling transition of `selN` sets `spiSelected`. The flag rises on the third rising clock edge after `selN` is first driven low: two synchroniser flops plus one edge register.
- R3: Fewer than three falling transitions leave `spiSelected` at 0. Transitions that occur while `normalMode` is low are not counted.
- R4: A configuration write while I2C is active, unlocked and in normal mode, with bit 1 of `cfgWrData` set to 1, sets `portLocked` and keeps `spiSelected` at 0. Any later `selN` activity is ignored.
- R5: A configuration write while I2C is active with bit 1 of `cfgWrData` at 0 leaves `portLocked` at 0, and the edge count still advances afterwards.
- R6: Any configuration write while SPI is active, unlocked and in normal mode sets `portLocked` and keeps `spiSelected` at 1, whatever the written word.
- R7: Once `portLocked` is 1, it and `spiSelected` keep their values until `rstN` goes low. This holds across `normalMode` falling and rising again.
- R8: A rising edge of `normalMode` while unlocked returns `spiSelected` to 0 and clears the edge count. A configuration write in that same cycle has no effect.
- R9: If an I2C lock write and the third counted falling edge fall in the same clock cycle, the lock wins: `portLocked` becomes 1 and `spiSelected` stays 0.
- R10: Configuration writes made while `normalMode` is low change neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hard reset / power loss |
| normalMode | input | 1 | High while the chip is in normal operating mode |
| selN | input | 1 | Raw shared slave-select pin, asynchronous |
| cfgWrEn | input | 1 | One-cycle strobe for a configuration-register write |
| cfgWrData | input | CFG_WIDTH | Word written with the strobe; bit 1 is the I2C lock bit |
| spiSelected | output | 1 | 1 when SPI is the active host port |
| portLocked | output | 1 | 1 when the port choice is frozen |

## Verification
Two functions can collide in one cycle: the third counted slave-select edge, which would switch the port to SPI, and a configuration write carrying the I2C lock bit. The bench lowers `selN` and, two negative clock edges later, raises the write strobe so that both land on the same rising edge. The expected outcome is I2C locked with `spiSelected` low, and later toggles of `selN` must not move it. A second pairing puts the normal-mode entry and a write in one cycle, and the write must be discarded.

// File: rtl/spl_pkg.sv
package spl_pkg;

  typedef enum logic [1:0] {
    PortI2cOpen   = 2'd0,
    PortSpiOpen   = 2'd1,
    PortI2cLocked = 2'd2,
    PortSpiLocked = 2'd3
  } portState_t;

  typedef struct packed {
    logic clearCount;
    logic countEdge;
  } edgeCtrl_t;

endpackage

// File: rtl/spl_edge_datapath.sv
module spl_edge_datapath
  import spl_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SWITCH_EDGES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selN,
  input  edgeCtrl_t ctrl,
  output logic      selFall,
  output logic      lastEdge
);
  localparam int CountW = $clog2(SWITCH_EDGES + 1);
  localparam logic [CountW-1:0] LastIdx = CountW'(SWITCH_EDGES - 1);
  localparam logic [CountW-1:0] MaxCount = CountW'(SWITCH_EDGES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   selPrev;
  logic [CountW-1:0]      edgeCount;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= selN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b1;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= 1'b1;
    else       selPrev <= syncChain[SYNC_STAGES-1];
  end

  assign selFall = selPrev & ~syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCount <= '0;
    end else if (ctrl.clearCount) begin
      edgeCount <= '0;
    end else if (ctrl.countEdge && edgeCount != MaxCount) begin
      edgeCount <= edgeCount + 1'b1;
    end
  end

  assign lastEdge = (edgeCount == LastIdx);

endmodule

// File: rtl/spl_select_ctrl.sv
module spl_select_ctrl
  import spl_pkg::*;
#(
  parameter int CFG_WIDTH = 16,
  parameter int LOCK_BIT  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 normalMode,
  input  logic                 cfgWrEn,
  input  logic [CFG_WIDTH-1:0] cfgWrData,
  input  logic                 selFall,
  input  logic                 lastEdge,
  output edgeCtrl_t            ctrl,
  output logic                 spiSelected,
  output logic                 portLocked
);
  portState_t state, stateNext;
  logic       normalPrev;
  logic       normalEntry;
  logic       lockReq;
  logic       isLocked;

  assign normalEntry = normalMode & ~normalPrev;
  assign lockReq     = cfgWrData[LOCK_BIT];
  assign isLocked    = (state == PortI2cLocked) || (state == PortSpiLocked);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) normalPrev <= 1'b0;
    else       normalPrev <= normalMode;
  end

  always_comb begin
    stateNext       = state;
    ctrl.clearCount = 1'b0;
    ctrl.countEdge  = 1'b0;
    if (normalEntry && !isLocked) begin
      stateNext       = PortI2cOpen;
      ctrl.clearCount = 1'b1;
    end else if (normalMode) begin
      unique case (state)
        PortI2cOpen: begin
          if (cfgWrEn && lockReq) begin
            stateNext = PortI2cLocked;
          end else if (selFall) begin
            ctrl.countEdge = 1'b1;
            if (lastEdge) stateNext = PortSpiOpen;
          end
        end
        PortSpiOpen: begin
          if (cfgWrEn) stateNext = PortSpiLocked;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PortI2cOpen;
    else       state <= stateNext;
  end

  assign spiSelected = (state == PortSpiOpen) || (state == PortSpiLocked);
  assign portLocked  = isLocked;

endmodule

// File: rtl/serial_port_selector.sv
module serial_port_selector
  import spl_pkg::*;
#(
  parameter int CFG_WIDTH    = 16,
  parameter int LOCK_BIT     = 1,
  parameter int SWITCH_EDGES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 normalMode,
  input  logic                 selN,
  input  logic                 cfgWrEn,
  input  logic [CFG_WIDTH-1:0] cfgWrData,
  output logic                 spiSelected,
  output logic                 portLocked
);
  edgeCtrl_t edgeCtrl;
  logic      selFall;
  logic      lastEdge;

  spl_edge_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .SWITCH_EDGES(SWITCH_EDGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .ctrl    (edgeCtrl),
    .selFall (selFall),
    .lastEdge(lastEdge)
  );

  spl_select_ctrl #(
    .CFG_WIDTH(CFG_WIDTH),
    .LOCK_BIT (LOCK_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .normalMode (normalMode),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .selFall    (selFall),
    .lastEdge   (lastEdge),
    .ctrl       (edgeCtrl),
    .spiSelected(spiSelected),
    .portLocked (portLocked)
  );

endmodule

// File: rtl/spl_checker.sv
module spl_checker (
  input logic clk,
  input logic rstN,
  input logic normalMode,
  input logic cfgWrEn,
  input logic spiSelected,
  input logic portLocked
);
  // R7: the lock flag never drops without reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    portLocked |=> portLocked);

  // R7: a locked choice is frozen
  assert_choice_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    portLocked |=> $stable(spiSelected));

  // R4 R6: locking only follows a configuration write
  assert_lock_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portLocked) |-> $past(cfgWrEn));

  // R10: nothing locks outside normal mode
  assert_lock_in_normal_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portLocked) |-> $past(normalMode));

  // R2: the switch to SPI only happens in normal mode
  assert_spi_in_normal_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSelected) |-> $past(normalMode));

  // R8: SPI is dropped only by a normal-mode entry
  assert_spi_drop_on_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiSelected) |-> !$past(normalMode, 2));

endmodule

bind serial_port_selector spl_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .normalMode (normalMode),
  .cfgWrEn    (cfgWrEn),
  .spiSelected(spiSelected),
  .portLocked (portLocked)
);

// File: tb/serial_port_selector_bench.sv
`timescale 1ns/1ps
module serial_port_selector_bench;
  localparam int CfgW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            normalMode = 1'b0;
  logic            selN = 1'b1;
  logic            cfgWrEn = 1'b0;
  logic [CfgW-1:0] cfgWrData = '0;
  logic            spiSelected;
  logic            portLocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_port_selector u_serial_port_selector (
    .clk        (clk),
    .rstN       (rstN),
    .normalMode (normalMode),
    .selN       (selN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .spiSelected(spiSelected),
    .portLocked (portLocked)
  );

  // behavioural reference: pin history queue plus integer state
  bit  selHist[$] = '{1'b1, 1'b1, 1'b1};
  int  mCount = 0;
  bit  mSpi = 0, mLock = 0, mNormPrev = 0;

  always @(posedge clk) begin
    bit sawFall;
    bit entry;
    if (!rstN) begin
      selHist = '{1'b1, 1'b1, 1'b1};
      mCount = 0; mSpi = 0; mLock = 0; mNormPrev = 0;
    end else begin
      sawFall = selHist[2] && !selHist[1];
      void'(selHist.pop_back());
      selHist.push_front(selN);
      entry = normalMode && !mNormPrev;
      mNormPrev = normalMode;
      if (entry && !mLock) begin
        mSpi = 0; mCount = 0;
      end else if (normalMode && !mLock) begin
        if (cfgWrEn && (mSpi || cfgWrData[1])) mLock = 1;
        else if (!mSpi && sawFall) begin
          mCount++;
          if (mCount >= 3) mSpi = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (spiSelected !== mSpi || portLocked !== mLock) begin
        fails++;
        $display("FAIL model R2 R4 R6 R8: spi=%0b lock=%0b expected spi=%0b lock=%0b at %0t",
                 spiSelected, portLocked, mSpi, mLock, $time);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectFlags(string req, bit expSpi, bit expLock);
    checks++;
    if (spiSelected !== expSpi || portLocked !== expLock) begin
      fails++;
      $display("FAIL %s: spi=%0b lock=%0b expected spi=%0b lock=%0b",
               req, spiSelected, portLocked, expSpi, expLock);
    end
  endtask

  task automatic pulseSel();
    selN = 1'b0; tick(4);
    selN = 1'b1; tick(4);
  endtask

  task automatic cfgWrite(logic [CfgW-1:0] d);
    cfgWrEn = 1'b1; cfgWrData = d; tick(1);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; normalMode = 1'b0; selN = 1'b1; tick(3);
    rstN = 1'b1; tick(1);
  endtask

  initial begin
    tick(2);
    expectFlags("R1 in reset", 0, 0);
    rstN = 1'b1; tick(2);
    expectFlags("R1 after release", 0, 0);

    // R3: edges outside normal mode are not counted
    pulseSel(); pulseSel(); pulseSel();
    expectFlags("R3 edges outside normal", 0, 0);
    normalMode = 1'b1; tick(2);
    pulseSel(); pulseSel();
    expectFlags("R3 two edges", 0, 0);

    // R2: exact switch timing on the third edge
    selN = 1'b0; tick(2);
    expectFlags("R2 before third clock", 0, 0);
    tick(1);
    expectFlags("R2 third clock", 1, 0);
    selN = 1'b1; tick(4);

    // R6: any write locks SPI
    cfgWrite(16'h0000); tick(1);
    expectFlags("R6 write locks spi", 1, 1);
    normalMode = 1'b0; tick(3); normalMode = 1'b1; tick(3);
    expectFlags("R7 spi kept over mode change", 1, 1);

    // R1 R5 R4: bit 1 clear does not lock; bit 1 set locks I2C
    doReset(); normalMode = 1'b1; tick(2);
    cfgWrite(16'hFFFD); tick(1);
    expectFlags("R5 no lock bit", 0, 0);
    pulseSel(); pulseSel(); pulseSel();
    expectFlags("R5 count still advances", 1, 0);

    doReset(); normalMode = 1'b1; tick(2);
    pulseSel(); pulseSel();
    cfgWrite(16'h0002); tick(1);
    expectFlags("R4 lock i2c", 0, 1);
    pulseSel(); pulseSel(); pulseSel(); pulseSel();
    expectFlags("R4 toggles ignored", 0, 1);
    normalMode = 1'b0; tick(2); normalMode = 1'b1; tick(2);
    expectFlags("R7 i2c kept over mode change", 0, 1);

    // R8: unlocked spi returns to i2c on entry; count cleared
    doReset(); normalMode = 1'b1; tick(2);
    pulseSel(); pulseSel(); pulseSel();
    expectFlags("R8 spi before exit", 1, 0);
    normalMode = 1'b0; tick(2);
    // R10: write outside normal mode ignored
    cfgWrite(16'h0002); tick(1);
    expectFlags("R10 write outside normal", 1, 0);
    normalMode = 1'b1;
    cfgWrEn = 1'b1; cfgWrData = 16'h0002; tick(1);
    cfgWrEn = 1'b0; cfgWrData = '0; tick(1);
    expectFlags("R8 entry returns i2c and drops write", 0, 0);
    pulseSel(); pulseSel();
    expectFlags("R8 count cleared", 0, 0);

    // R9: lock write on the same edge as the third counted edge
    selN = 1'b0; tick(2);
    cfgWrEn = 1'b1; cfgWrData = 16'h0002; tick(1);
    cfgWrEn = 1'b0; cfgWrData = '0; tick(1);
    expectFlags("R9 lock wins", 0, 1);
    selN = 1'b1; tick(4);
    pulseSel(); pulseSel(); pulseSel();
    expectFlags("R9 still i2c", 0, 1);

    // R1: reset clears a lock
    rstN = 1'b0; tick(1);
    expectFlags("R1 reset clears lock", 0, 0);
    rstN = 1'b1; tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R1: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule